// File: doc/BRIEF.md
# CAN Receive Flag Register

This block holds the receive-side event flags of a CAN controller together with a live view of the receiver and transmitter link-state codes. Four hardware condition inputs (wakeup, status change, overrun, receive buffer full) raise sticky flags. Software reads the flags over a small register bus. It acknowledges a flag by writing a 1 to its bit. The acknowledge takes effect only once the raising condition has dropped.

A second register at its own address holds one interrupt enable per flag. The interrupt output goes high while any enabled flag is set. While the controller sits in initialization mode, meaning both the request and the acknowledge inputs are high, all flags are forced clear and writes to them are dropped. The two state fields keep tracking their inputs in that mode.

Top module: `can_rx_flag_reg`

## Requirements
- R1: After reset every flag and every enable reads 0 and `irq` is low.
- R2: The flag register sits at address 0. Its bit 7 is wakeup, bit 6 is status change, bits 5:4 are the receiver state, bits 3:2 are the transmitter state, bit 1 is overrun and bit 0 is receive full. The enable register sits at address 1 and uses the same positions (7, 6, 1, 0) for its four enables; its bits 5:2 read 0. Any other address reads 0.
- R3: Outside initialization mode, a flag whose condition input is high at a clock edge reads 1 after that edge.
- R4: Writing a 1 to a flag bit at address 0 clears that flag at the edge if its condition is low. Writing 0 to a flag bit leaves it unchanged.
- R5: A clear write to a flag whose condition is high at the same edge is ignored, and the flag stays 1.
- R6: While `init_req` and `init_ack` are both 1, every flag is cleared at each edge. Condition inputs and flag writes have no effect. Normal behaviour resumes at the first edge where they are not both 1.
- R7: The state fields always show `rx_state` and `tx_state` as they are now, in or out of initialization mode. Writes to bits 5:2 of address 0 have no effect.
- R8: `irq` is 1 exactly when some flag and its enable are both 1. The state fields never drive `irq`.
- R9: The enable register can be written at any time, including during initialization mode. A write to address 1 does not change the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cond_wake | input | 1 | Wakeup condition |
| cond_stchg | input | 1 | Status-change condition |
| cond_ovr | input | 1 | Overrun condition |
| cond_rxfull | input | 1 | Receive-buffer-full condition |
| rx_state | input | 2 | Receiver state code |
| tx_state | input | 2 | Transmitter state code |
| init_req | input | 1 | Initialization-mode request |
| init_ack | input | 1 | Initialization-mode acknowledge |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch four things on every cycle: each condition sets its flag, a flag holds while its condition persists, zero-writes keep a flag and clear-writes drop it, and initialization mode empties all flags. They also check that the state fields on the read port track their inputs and that `irq` stays low with no enabled flag set. Only the bench scenarios show the full sequence of flag contents across mixed conditions and writes, the read-only state bits surviving a write of all ones, and an enable write made during initialization mode. They also show that flags come back at the first edge after initialization mode ends.

// File: rtl/can_rflg_pkg.sv
package can_rflg_pkg;

    localparam int NUM_FLAGS = 4;
    localparam int DATA_W    = 8;
    localparam int STATE_W   = 2;
    localparam int RXST_LSB  = 4;
    localparam int TXST_LSB  = 2;

    // Flag vector index order: 0 receive full, 1 overrun, 2 status change, 3 wakeup
    localparam int FL_RXFULL = 0;
    localparam int FL_OVR    = 1;
    localparam int FL_STCHG  = 2;
    localparam int FL_WAKE   = 3;

    typedef struct packed {
        logic [STATE_W-1:0] rx;
        logic [STATE_W-1:0] tx;
    } link_state_t;

    typedef struct packed {
        logic flag_wr;
        logic en_wr;
        logic sel_flag;
        logic sel_en;
    } bus_dec_t;

    // Bit position of a flag inside the 8-bit register image
    function automatic int flag_bit(input int idx);
        return (idx < 2) ? idx : idx + 4;
    endfunction

    function automatic logic [DATA_W-1:0] scatter(input logic [NUM_FLAGS-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_FLAGS; i++) r[flag_bit(i)] = v[i];
        return r;
    endfunction

    function automatic logic [NUM_FLAGS-1:0] gather(input logic [DATA_W-1:0] d);
        logic [NUM_FLAGS-1:0] r;
        for (int i = 0; i < NUM_FLAGS; i++) r[i] = d[flag_bit(i)];
        return r;
    endfunction

endpackage

// File: rtl/rflg_decode.sv
module rflg_decode
    import can_rflg_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int FLAG_ADDR = 0,
    parameter int EN_ADDR   = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              in_init,
    output bus_dec_t          dec
);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_ADDR);

    always_comb begin
        dec.sel_flag = (addr == FLAG_A);
        dec.sel_en   = (addr == EN_A);
        dec.flag_wr  = wr && dec.sel_flag && !in_init;
        dec.en_wr    = wr && dec.sel_en;
    end
endmodule

// File: rtl/rflg_cell.sv
module rflg_cell (
    input  logic clk,
    input  logic rst,
    input  logic hold_clr,
    input  logic cond,
    input  logic clr_req,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst || hold_clr) begin
            flag_q <= 1'b0;
        end else if (cond) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rflg_enable.sv
module rflg_enable
    import can_rflg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [NUM_FLAGS-1:0] en_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr) begin
            en_q <= gather(wdata);
        end
    end
endmodule

// File: rtl/rflg_readout.sv
module rflg_readout
    import can_rflg_pkg::*;
(
    input  bus_dec_t             dec,
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [NUM_FLAGS-1:0] ens,
    input  link_state_t          lstate,
    output logic [DATA_W-1:0]    rdata
);
    always_comb begin
        rdata = '0;
        if (dec.sel_flag) begin
            rdata = scatter(flags);
            rdata[RXST_LSB +: STATE_W] = lstate.rx;
            rdata[TXST_LSB +: STATE_W] = lstate.tx;
        end else if (dec.sel_en) begin
            rdata = scatter(ens);
        end
    end
endmodule

// File: rtl/can_rx_flag_reg.sv
module can_rx_flag_reg
    import can_rflg_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int FLAG_ADDR = 0,
    parameter int EN_ADDR   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              cond_wake,
    input  logic              cond_stchg,
    input  logic              cond_ovr,
    input  logic              cond_rxfull,
    input  logic [1:0]        rx_state,
    input  logic [1:0]        tx_state,
    input  logic              init_req,
    input  logic              init_ack,
    output logic              irq
);
    logic                 in_init;
    logic [NUM_FLAGS-1:0] cond_v;
    logic [NUM_FLAGS-1:0] clr_v;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_FLAGS-1:0] en_q;
    bus_dec_t             dec;
    link_state_t          lstate;

    assign in_init = init_req && init_ack;

    always_comb begin
        cond_v            = '0;
        cond_v[FL_RXFULL] = cond_rxfull;
        cond_v[FL_OVR]    = cond_ovr;
        cond_v[FL_STCHG]  = cond_stchg;
        cond_v[FL_WAKE]   = cond_wake;
        lstate.rx         = rx_state;
        lstate.tx         = tx_state;
    end

    rflg_decode #(
        .ADDR_W    (ADDR_W),
        .FLAG_ADDR (FLAG_ADDR),
        .EN_ADDR   (EN_ADDR)
    ) u_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .in_init (in_init),
        .dec     (dec)
    );

    assign clr_v = {NUM_FLAGS{dec.flag_wr}} & gather(bus_wdata);

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        rflg_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .hold_clr (in_init),
            .cond     (cond_v[g]),
            .clr_req  (clr_v[g]),
            .flag_q   (flag_q[g])
        );
    end

    rflg_enable u_en (
        .clk   (clk),
        .rst   (rst),
        .wr    (dec.en_wr),
        .wdata (bus_wdata),
        .en_q  (en_q)
    );

    rflg_readout u_rd (
        .dec    (dec),
        .flags  (flag_q),
        .ens    (en_q),
        .lstate (lstate),
        .rdata  (bus_rdata)
    );

    assign irq = |(flag_q & en_q);

endmodule

// File: rtl/rflg_checker.sv
module rflg_checker
    import can_rflg_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int FLAG_ADDR = 0
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic [7:0]           bus_wdata,
    input logic [7:0]           bus_rdata,
    input logic [NUM_FLAGS-1:0] cond,
    input logic [NUM_FLAGS-1:0] flags,
    input logic [NUM_FLAGS-1:0] ens,
    input logic [1:0]           rx_state,
    input logic [1:0]           tx_state,
    input logic                 init_req,
    input logic                 init_ack,
    input logic                 irq
);
    localparam logic [ADDR_W-1:0] FA = ADDR_W'(FLAG_ADDR);
    logic init_m;
    logic flag_wr;
    assign init_m  = init_req && init_ack;
    assign flag_wr = bus_wr && (bus_addr == FA);

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_chk
        localparam int BP = flag_bit(g);

        a_r3_cond_sets: assert property (@(posedge clk) disable iff (rst)
            (cond[g] && !init_m) |=> flags[g]);

        a_r5_clear_blocked: assert property (@(posedge clk) disable iff (rst)
            (flags[g] && cond[g] && !init_m) |=> flags[g]);

        a_r4_zero_keeps: assert property (@(posedge clk) disable iff (rst)
            (flags[g] && !init_m && flag_wr && !bus_wdata[BP]) |=> flags[g]);

        a_r4_one_clears: assert property (@(posedge clk) disable iff (rst)
            (!cond[g] && !init_m && flag_wr && bus_wdata[BP]) |=> !flags[g]);
    end

    a_r6_init_empties: assert property (@(posedge clk) disable iff (rst)
        init_m |=> (flags == '0));

    a_r7_state_view: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == FA) |-> (bus_rdata[5:4] == rx_state && bus_rdata[3:2] == tx_state));

    a_r8_no_irq_idle: assert property (@(posedge clk) disable iff (rst)
        ((flags & ens) == '0) |-> !irq);

    a_r1_reset_clean: assert property (@(posedge clk)
        rst |=> (flags == '0 && ens == '0));

endmodule

bind can_rx_flag_reg rflg_checker #(
    .ADDR_W    (ADDR_W),
    .FLAG_ADDR (FLAG_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cond      (cond_v),
    .flags     (flag_q),
    .ens       (en_q),
    .rx_state  (rx_state),
    .tx_state  (tx_state),
    .init_req  (init_req),
    .init_ack  (init_ack),
    .irq       (irq)
);

// File: tb/tb_can_rx_flag_reg.sv
module tb_can_rx_flag_reg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cond_wake = 0, cond_stchg = 0, cond_ovr = 0, cond_rxfull = 0;
    logic [1:0] rx_state = 2'b10;
    logic [1:0] tx_state = 2'b01;
    logic       init_req = 0, init_ack = 0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    can_rx_flag_reg dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cond_wake(cond_wake), .cond_stchg(cond_stchg), .cond_ovr(cond_ovr),
        .cond_rxfull(cond_rxfull), .rx_state(rx_state), .tx_state(tx_state),
        .init_req(init_req), .init_ack(init_ack), .irq(irq)
    );

    // {cond[3:0] = wake,stchg,ovr,rxfull ; wr ; addr[1:0] ; wdata[7:0] ; expected flag read[7:0]}
    // state fields fixed at rx=10, tx=01 -> 0x24 in every expected image
    localparam int NV = 10;
    localparam logic [22:0] VEC [NV] = '{
        {4'b0001, 1'b0, 2'd0, 8'h00, 8'h25},  // R3 rxfull sets
        {4'b0001, 1'b1, 2'd0, 8'h01, 8'h25},  // R5 clear blocked
        {4'b0000, 1'b1, 2'd0, 8'h00, 8'h25},  // R4 zero write keeps
        {4'b0000, 1'b1, 2'd0, 8'h01, 8'h24},  // R4 one write clears
        {4'b1010, 1'b0, 2'd0, 8'h00, 8'hA6},  // R3 wake + overrun
        {4'b0000, 1'b1, 2'd0, 8'h80, 8'h26},  // R4 clear wake only
        {4'b0100, 1'b1, 2'd0, 8'h02, 8'h64},  // R3/R4 stchg up, ovr down
        {4'b0100, 1'b1, 2'd0, 8'h40, 8'h64},  // R5 set wins
        {4'b0000, 1'b1, 2'd0, 8'hFF, 8'h24},  // R7 state bits not writable
        {4'b1111, 1'b1, 2'd1, 8'h00, 8'hE7}   // R9 enable write leaves flags
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] c, input logic w, input logic [1:0] a,
                         input logic [7:0] d);
        @(negedge clk);
        {cond_wake, cond_stchg, cond_ovr, cond_rxfull} = c;
        bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_addr = 2'd0;
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = 2'd0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        rd(2'd0, v); check("R1 flags", v, 8'h24);
        rd(2'd1, v); check("R1 enables", v, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][22:19], VEC[i][18], VEC[i][17:16], VEC[i][15:8]);
            rd(2'd0, v);
            check($sformatf("R3/R4/R5/R7 table step %0d", i), v, VEC[i][7:0]);
        end

        // R8: all flags set, no enables
        check("R8 irq off", {7'd0, irq}, 8'h00);
        apply(4'b1111, 1'b1, 2'd1, 8'h01);
        check("R8 irq on", {7'd0, irq}, 8'h01);
        rd(2'd1, v); check("R2 enable image", v, 8'h01);
        apply(4'b1111, 1'b1, 2'd1, 8'h3C);
        rd(2'd1, v); check("R2 enable unused bits", v, 8'h00);
        check("R8 state no irq", {7'd0, irq}, 8'h00);
        rd(2'd2, v); check("R2 other address", v, 8'h00);

        apply(4'b0000, 1'b1, 2'd0, 8'hFF);
        apply(4'b0000, 1'b1, 2'd1, 8'hC3);
        check("R8 enabled but empty", {7'd0, irq}, 8'h00);

        // R6: initialization mode
        apply(4'b0001, 1'b0, 2'd0, 8'h00);
        check("R8 rxfull irq", {7'd0, irq}, 8'h01);
        @(negedge clk);
        init_req = 1'b1; init_ack = 1'b1;
        apply(4'b0001, 1'b0, 2'd0, 8'h00);
        rd(2'd0, v); check("R6 flags held clear", v, 8'h24);
        check("R6 irq clear", {7'd0, irq}, 8'h00);
        rx_state = 2'b01; tx_state = 2'b11;
        #1;
        rd(2'd0, v); check("R7 state live in init", v, 8'h1C);
        apply(4'b0001, 1'b1, 2'd1, 8'h02);
        rd(2'd1, v); check("R9 enable write in init", v, 8'h02);
        rd(2'd0, v); check("R6 cond ignored in init", v, 8'h1C);
        @(negedge clk);
        init_req = 1'b0; init_ack = 1'b0;
        apply(4'b0011, 1'b0, 2'd0, 8'h00);
        rd(2'd0, v); check("R6 resume after init", v, 8'h1F);
        check("R8 overrun irq", {7'd0, irq}, 8'h01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule